// File: doc/BRIEF.md
# Second-Order Masked 4-bit S-box

This block computes a fixed 4-bit to 4-bit substitution on data held as three Boolean shares. The unmasked value is never formed in the datapath. Each of the four coordinate functions is cubic. Each one is expanded into 27 partial results, one per row of a share-index table. In every row each input variable draws on exactly one of its three shares. The partial results receive a ring of fresh random bits and are then captured in a register stage. After the register, each group of nine is folded into one of three output shares.

A caller presents three 4-bit shares and 108 fresh random bits on every cycle. One clock edge later it reads back three 4-bit shares whose XOR is the substituted value. The unit accepts a new input on every cycle. A cipher datapath can therefore chain it with a register between nonlinear layers. The partial results are kept apart until they have been registered, so glitches cannot recombine shares of the same variable.

Top module: `tsbx_masked_sbox`

## Requirements
- R1: An asynchronous active-low reset clears all three output shares to 0. They stay 0 while reset is held and until the first rising edge after release.
- R2: Bit i of every share carries variable i of the input. Let v be the XOR of the three input shares sampled at a rising edge. After that edge, the XOR of the three output shares equals S(v), where S maps 0..15 to B,F,3,2,A,C,9,1,6,7,8,0,E,5,D,4 (hex). A new input is accepted on every cycle, so the latency is exactly one cycle.
- R3: Each coordinate bit is built as 27 partial results. The XOR of these 27 results equals that bit of S applied to the unmasked input.
- R4: Partial result r = 9a+3b+c uses share a of variable 0, share b of variable 1, share c of variable 2 and share (-(a+b+c) mod 3) of variable 3. Each output share k collects the rows with a = k. As a result, output share k depends on input bit 0 only through bit 0 of input share k.
- R5: The 27 partial results of coordinate bit j are refreshed with rnd_i[27j+26:27j] as a ring. Row s receives random bits s and s-1, and row 0 receives bits 0 and 26. The XOR of the outputs does not depend on the random bits.
- R6: The refreshed partial results are registered before any of them are combined. Output share k, bit j, is the XOR of registered rows 9k through 9k+8 of coordinate j.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sh0_i | input | 4 | Input share 0 |
| sh1_i | input | 4 | Input share 1 |
| sh2_i | input | 4 | Input share 2 |
| rnd_i | input | 108 | Fresh random bits, 27 per coordinate bit |
| q0_o | output | 4 | Output share 0 |
| q1_o | output | 4 | Output share 1 |
| q2_o | output | 4 | Output share 2 |

## Verification
The assertions require the inputs to be settled at each rising edge. They require nothing of the random bits, because any value of rnd_i must leave the share sums unchanged. The bench therefore changes shares and random bits only on falling edges. It draws masks freely, including all-zero masks and all-zero or all-one random words. For the share-separation check it flips bit 0 of two input shares together, which leaves the unmasked value unchanged.

// File: rtl/tsbx_pkg.sv
package tsbx_pkg;
  localparam int NSH   = 3;
  localparam int NVAR  = 4;
  localparam int NROW  = NSH ** (NVAR - 1);
  localparam int NMONO = 2 ** NVAR;
  localparam int RND_W = NVAR * NROW;

  typedef logic [NVAR-1:0] nib_t;
  typedef logic [NSH-1:0][NVAR-1:0] shares_t;

  function automatic nib_t sbox_lut(nib_t x);
    case (x)
      4'h0: return 4'hB;  4'h1: return 4'hF;  4'h2: return 4'h3;  4'h3: return 4'h2;
      4'h4: return 4'hA;  4'h5: return 4'hC;  4'h6: return 4'h9;  4'h7: return 4'h1;
      4'h8: return 4'h6;  4'h9: return 4'h7;  4'hA: return 4'h8;  4'hB: return 4'h0;
      4'hC: return 4'hE;  4'hD: return 4'h5;  4'hE: return 4'hD;  default: return 4'h4;
    endcase
  endfunction

  // Share index of variable v in row r; the last index closes the sum to 0 mod NSH.
  function automatic int tup(int r, int v);
    int s;
    s = 0;
    if (v < NVAR - 1) return (r / (NSH ** (NVAR - 2 - v))) % NSH;
    for (int u = 0; u < NVAR - 1; u++) s += (r / (NSH ** (NVAR - 2 - u))) % NSH;
    return (NSH * NVAR - s) % NSH;
  endfunction

  // Algebraic normal form coefficients of one coordinate (Moebius transform).
  function automatic logic [NMONO-1:0] anf_of(int coord);
    logic [NMONO-1:0] c;
    nib_t y;
    c = '0;
    for (int m = 0; m < NMONO; m++)
      for (int x = 0; x < NMONO; x++)
        if ((x & ~m & (NMONO - 1)) == 0) begin
          y = sbox_lut(nib_t'(x));
          c[m] = c[m] ^ y[coord];
        end
    return c;
  endfunction

  // A row owns a monomial's share combination if no earlier row shows the same one.
  function automatic logic [NMONO-1:0] owner_mask(int r);
    logic [NMONO-1:0] own;
    logic same;
    own = '1;
    for (int m = 0; m < NMONO; m++)
      for (int q = 0; q < r; q++) begin
        same = 1'b1;
        for (int v = 0; v < NVAR; v++)
          if (((m >> v) & 1) == 1 && tup(q, v) != tup(r, v)) same = 1'b0;
        if (same) own[m] = 1'b0;
      end
    return own;
  endfunction
endpackage

// File: rtl/tsbx_share_eval.sv
module tsbx_share_eval
  import tsbx_pkg::*;
#(
  parameter int COORD = 0
) (
  input  shares_t         sh,
  output logic [NROW-1:0] part
);
  localparam logic [NMONO-1:0] COEF = anf_of(COORD);

  for (genvar r = 0; r < NROW; r++) begin : g_row
    localparam logic [NMONO-1:0] USE = COEF & owner_mask(r);
    logic bit_r;
    always_comb begin
      logic acc, p;
      acc = 1'b0;
      for (int m = 0; m < NMONO; m++) begin
        if (USE[m]) begin
          p = 1'b1;
          for (int v = 0; v < NVAR; v++)
            if (((m >> v) & 1) == 1) p = p & sh[tup(r, v)][v];
          acc = acc ^ p;
        end
      end
      bit_r = acc;
    end
    assign part[r] = bit_r;
  end
endmodule

// File: rtl/tsbx_ring_refresh.sv
module tsbx_ring_refresh #(
  parameter int N = 27
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] r,
  output logic [N-1:0] y
);
  for (genvar i = 0; i < N; i++) begin : g_ring
    if (i == 0) begin : g_first
      assign y[i] = x[i] ^ r[0] ^ r[N-1];
    end else begin : g_rest
      assign y[i] = x[i] ^ r[i-1] ^ r[i];
    end
  end
endmodule

// File: rtl/tsbx_compress.sv
module tsbx_compress #(
  parameter int NIN  = 27,
  parameter int NOUT = 3
) (
  input  logic [NIN-1:0]  s,
  output logic [NOUT-1:0] d
);
  localparam int GRP = NIN / NOUT;
  for (genvar k = 0; k < NOUT; k++) begin : g_dom
    assign d[k] = ^s[k*GRP +: GRP];
  end
endmodule

// File: rtl/tsbx_masked_sbox.sv
module tsbx_masked_sbox
  import tsbx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NVAR-1:0]  sh0_i,
  input  logic [NVAR-1:0]  sh1_i,
  input  logic [NVAR-1:0]  sh2_i,
  input  logic [RND_W-1:0] rnd_i,
  output logic [NVAR-1:0]  q0_o,
  output logic [NVAR-1:0]  q1_o,
  output logic [NVAR-1:0]  q2_o
);
  shares_t in_sh, q_sh;
  assign in_sh = {sh2_i, sh1_i, sh0_i};

  // Observation wires for the checks
  nib_t plain, plain_sb;
  assign plain    = sh0_i ^ sh1_i ^ sh2_i;
  assign plain_sb = sbox_lut(plain);

  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  for (genvar b = 0; b < NVAR; b++) begin : g_coord
    logic [NROW-1:0] raw, fresh, held;
    logic [NSH-1:0]  dom;

    tsbx_share_eval #(.COORD(b)) u_eval (.sh(in_sh), .part(raw));

    tsbx_ring_refresh #(.N(NROW)) u_ring (
      .x(raw), .r(rnd_i[b*NROW +: NROW]), .y(fresh)
    );

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) held <= '0;
      else        held <= fresh;

    tsbx_compress #(.NIN(NROW), .NOUT(NSH)) u_fold (.s(held), .d(dom));

    for (genvar k = 0; k < NSH; k++) begin : g_out
      assign q_sh[k][b] = dom[k];
    end

    // R3
    raw_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (^raw) == plain_sb[b]) else $error("partial results do not sum to coordinate");
    // R5
    refresh_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (^fresh) == (^raw)) else $error("ring refresh changed the share sum");
    // R6
    domain_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (^dom) == (^held)) else $error("folding changed the share sum");
  end

  assign q0_o = q_sh[0];
  assign q1_o = q_sh[1];
  assign q2_o = q_sh[2];

  // R2
  out_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (q0_o ^ q1_o ^ q2_o) == sbox_lut($past(plain)))
    else $error("output shares do not encode S of previous input");
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q0_o == '0 && q1_o == '0 && q2_o == '0))
    else $error("outputs not cleared by reset");
endmodule

// File: tb/tsbx_masked_sbox_test.sv
`timescale 1ns/1ps
module tsbx_masked_sbox_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n;
  logic [3:0]   s0, s1, s2;
  logic [107:0] rnd;
  logic [3:0]   q0, q1, q2;

  tsbx_masked_sbox uut (
    .clk(clk), .rst_n(rst_n), .sh0_i(s0), .sh1_i(s1), .sh2_i(s2),
    .rnd_i(rnd), .q0_o(q0), .q1_o(q1), .q2_o(q2)
  );

  localparam logic [63:0] SREF = 64'h4D5E087619CA23FB;
  int total = 0, bad = 0;
  bit finished = 0;
  logic [3:0] expq[$];
  logic [3:0] g0, g1, g2;

  function automatic logic [3:0] sref(logic [3:0] v);
    return SREF[v*4 +: 4];
  endfunction

  function automatic logic [107:0] rnd108();
    logic [127:0] t;
    t = {$urandom, $urandom, $urandom, $urandom};
    return t[107:0];
  endfunction

  function automatic logic [3:0] pick(int k, logic [3:0] a, logic [3:0] b, logic [3:0] c);
    return (k == 0) ? a : (k == 1) ? b : c;
  endfunction

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle of the reference model: compare what the last edge produced, then drive.
  task automatic cyc(logic [3:0] a, logic [3:0] b, logic [3:0] c, logic [107:0] r, string tag);
    @(negedge clk);
    g0 = q0; g1 = q1; g2 = q2;
    if (expq.size() > 0) check(tag, {8'h0, q0 ^ q1 ^ q2}, {8'h0, expq.pop_front()});
    s0 = a; s1 = b; s2 = c; rnd = r;
    expq.push_back(sref(a ^ b ^ c));
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [3:0] m1, m2, a0, a1, a2, ka, kb;
    logic [107:0] rf;
    rst_n = 1'b0; s0 = '0; s1 = '0; s2 = '0; rnd = '0;
    repeat (3) @(negedge clk);
    check("R1 held in reset", {q0, q1, q2}, 12'h0);
    rst_n = 1'b1;
    #1 check("R1 after release before edge", {q0, q1, q2}, 12'h0);

    // R2 R3 R6: every input value under several masks, streamed back to back
    for (int v = 0; v < 16; v++) begin
      for (int k = 0; k < 4; k++) begin
        m1 = (k == 0) ? 4'h0 : 4'($urandom);
        m2 = (k == 0) ? 4'h0 : 4'($urandom);
        cyc(4'(v) ^ m1 ^ m2, m1, m2, rnd108(), "R2,R3,R6 stream");
      end
    end

    // R5: the same masked input under zero, all-one and random refresh bits
    m1 = 4'h6; m2 = 4'hC;
    cyc(4'h9 ^ m1 ^ m2, m1, m2, '0, "R5 rnd zero");
    cyc(4'h9 ^ m1 ^ m2, m1, m2, '1, "R5 rnd ones");
    cyc(4'h9 ^ m1 ^ m2, m1, m2, rnd108(), "R5 rnd random");
    cyc(4'h3, 4'h3, 4'h0, rnd108(), "R5 zero value");

    // R4: share k of the output ignores bit 0 of the other two input shares
    for (int k = 0; k < 3; k++) begin
      a0 = 4'($urandom); a1 = 4'($urandom); a2 = 4'($urandom);
      rf = rnd108();
      cyc(a0, a1, a2, rf, "R4 base");
      cyc(a0 ^ ((k != 0) ? 4'h1 : 4'h0), a1 ^ ((k != 1) ? 4'h1 : 4'h0),
          a2 ^ ((k != 2) ? 4'h1 : 4'h0), rf, "R4 flipped");
      ka = pick(k, g0, g1, g2);
      cyc(a0, a1, a2, rf, "R4 base again");
      kb = pick(k, g0, g1, g2);
      check($sformatf("R4 domain %0d bit0", k), {8'h0, kb}, {8'h0, ka});
    end

    // R1: asynchronous reset in the middle of a stream
    cyc(4'h5, 4'hA, 4'h3, rnd108(), "R2 pre-reset");
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 async clear", {q0, q1, q2}, 12'h0);
    expq.delete();
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) cyc(4'($urandom), 4'($urandom), 4'($urandom), rnd108(), "R2 after reset");
    cyc(4'h0, 4'h0, 4'h0, '0, "R2 flush");

    finished = 1;
    summary();
    $finish;
  end
endmodule